// File: doc/BRIEF.md
# Single-channel transfer engine with control and status registers

This block is the register front end and beat sequencer for one data-movement channel that copies between an on-chip bus address space and a PCIe-side address space. Software programs a 64-bit PCIe-side address, a 32-bit internal address and a byte count through a 32-bit register port. It then sets the channel start bit while the global enable is on. The engine presents one beat at a time on a valid/ready handshake. Each accepted beat moves 8 bytes: it advances both addresses and lowers the remaining count.

A channel finishes in one of four ways, and each has its own sticky status flag and its own interrupt enable. A normal end leaves a count of zero. A PCIe-side error or an internal-bus error halts the channel and leaves the bytes not yet moved readable in the count register. An abort comes from a count that breaks the size rules, or from software pulling the start bit or the global enable while the channel is running. Software clears a flag by writing the status word back as it was read. One level-sensitive interrupt line combines the enabled flags.

Top module: `xfer_chan_ctl`

## Requirements
- R1: After reset every register reads 0, `beat_valid_o` is 0 and `irq_o` is 0.
- R2: The global register is at 0x0000. The channel registers sit at CH_BASE (default 0x100) plus an offset: PCIe address low at +0x00, PCIe address high at +0x04, internal address at +0x08, byte count at +0x10, control at +0x28, status at +0x2C. Reads are combinational from `reg_addr_i`. A write takes effect at the clock edge where `reg_we_i` is 1.
- R3: A transfer launches one cycle after global bit 31 (enable) and control bit 31 (start) are both 1 and the count is nonzero. While it runs, global bit 16 reads 1 and `beat_valid_o` is 1. With a zero count or the enable at 0, no beat is offered and the start bit stays set.
- R4: A launch whose count exceeds MAX_CNT (default 0x7FFFFFF) or is not a multiple of 8 sets the abort flag (status bit 12), clears the start bit, offers no beat and leaves the count unchanged.
- R5: Each accepted beat (valid and ready, no error input) lowers the count by 8 and raises the PCIe-side address and the internal address by 8 each. The carry runs from the low into the high PCIe address word. The beat addresses are the current register values.
- R6: When the beat that brings the count to 0 is accepted, the end flag (status bit 0) sets, the start bit clears and the active flag and `beat_valid_o` drop.
- R7: `pcie_err_i` during an active cycle sets status bit 11, and `int_err_i` sets status bit 9. The channel stops, the start bit clears, and the count keeps the bytes not yet moved. A beat in that same cycle is not counted.
- R8: Clearing the start bit or the global enable while the channel runs stops it on the next cycle, sets the abort flag and keeps the count.
- R9: Writing 1 to a status flag bit (0, 9, 11, 12) clears it, and writing 0 leaves it. The enable bits 3 (end), 25 (internal-bus error), 27 (PCIe error) and 28 (abort) are read/write.
- R10: `irq_o` is 1 exactly while some flag is set together with its matching enable.
- R11: While the channel runs, writes to the address and count registers are ignored.
- R12: Control bit 30 sets the direction, shown on `beat_dir_o`: 1 moves data from the internal bus to PCIe, 0 moves data from PCIe to the internal bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| beat_valid_o | output | 1 | Beat offered |
| beat_ready_i | input | 1 | Beat accepted |
| beat_dir_o | output | 1 | 1: internal to PCIe, 0: PCIe to internal |
| beat_pcie_addr_o | output | 64 | PCIe-side address of current beat |
| beat_int_addr_o | output | 32 | Internal address of current beat |
| pcie_err_i | input | 1 | PCIe-side error |
| int_err_i | input | 1 | Internal-bus error |
| irq_o | output | 1 | Interrupt |

## Verification
The bench lowers MAX_CNT to 0x40 and keeps the 8-byte beat. With these values every byte count from 1 to 80 can be swept in full. The sweep covers both sides of the upper limit and every misaligned residue, so each launch either completes in at most eight beats or aborts. The PCIe low word starts at 0xFFFFFFC0, which pushes the address carry into the high word inside that range. Error and software-stop cases are placed after a known number of accepted beats, so the remaining count can be predicted exactly.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int unsigned NFLAG = 4;  // 0 end, 1 int-bus err, 2 pcie err, 3 abort

  localparam int unsigned OFF_PA_LO = 'h00;
  localparam int unsigned OFF_PA_HI = 'h04;
  localparam int unsigned OFF_IA    = 'h08;
  localparam int unsigned OFF_CNT   = 'h10;
  localparam int unsigned OFF_CTRL  = 'h28;
  localparam int unsigned OFF_STAT  = 'h2C;

  localparam int unsigned GLB_EN_B  = 31;
  localparam int unsigned GLB_ACT_B = 16;
  localparam int unsigned CTL_GO_B  = 31;
  localparam int unsigned CTL_DIR_B = 30;

  function automatic int unsigned flag_pos(input int unsigned k);
    case (k)
      0:       return 0;
      1:       return 9;
      2:       return 11;
      default: return 12;
    endcase
  endfunction

  function automatic int unsigned en_pos(input int unsigned k);
    case (k)
      0:       return 3;
      1:       return 25;
      2:       return 27;
      default: return 28;
    endcase
  endfunction
endpackage

// File: rtl/xfer_size_chk.sv
module xfer_size_chk #(
  parameter int unsigned BEAT_BYTES = 8,
  parameter logic [31:0] MAX_CNT    = 32'h07FF_FFFF
) (
  input  logic [31:0] cnt_i,
  output logic        ok_o
);
  localparam int unsigned SH = $clog2(BEAT_BYTES);

  logic aligned;
  generate
    if (SH == 0) begin : g_any
      assign aligned = 1'b1;
    end else begin : g_mask
      assign aligned = (cnt_i[SH-1:0] == '0);
    end
  endgenerate

  assign ok_o = aligned && (cnt_i <= MAX_CNT);
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine #(
  parameter int unsigned BEAT_BYTES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        go_i,
  input  logic        size_ok_i,
  input  logic        wr_pa_lo_i,
  input  logic        wr_pa_hi_i,
  input  logic        wr_ia_i,
  input  logic        wr_cnt_i,
  input  logic [31:0] wdata_i,
  input  logic        ready_i,
  input  logic        pcie_err_i,
  input  logic        int_err_i,
  output logic        active_o,
  output logic [63:0] pa_o,
  output logic [31:0] ia_o,
  output logic [31:0] cnt_o,
  output logic [xfer_pkg::NFLAG-1:0] ev_o,
  output logic        stop_o
);
  localparam logic [31:0] STEP   = 32'(BEAT_BYTES);
  localparam logic [63:0] STEP64 = 64'(BEAT_BYTES);

  logic        active_q;
  logic [63:0] pa_q;
  logic [31:0] ia_q, cnt_q;
  logic        launch, bad_launch, err, halt, beat, last;

  always_comb begin
    launch     = !active_q && en_i && go_i && (cnt_q != '0);
    bad_launch = launch && !size_ok_i;
    err        = active_q && (pcie_err_i || int_err_i);
    halt       = active_q && !err && !(en_i && go_i);
    beat       = active_q && !err && !halt && ready_i;
    last       = beat && (cnt_q == STEP);
    ev_o[0]    = last;
    ev_o[1]    = active_q && int_err_i;
    ev_o[2]    = active_q && pcie_err_i;
    ev_o[3]    = halt || bad_launch;
    stop_o     = err || halt || last || bad_launch;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
    end else if (launch && size_ok_i) begin
      active_q <= 1'b1;
    end else if (err || halt || last) begin
      active_q <= 1'b0;
    end
  end

  // software loads only while idle; beats advance the live copies
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q  <= '0;
      ia_q  <= '0;
      cnt_q <= '0;
    end else if (beat) begin
      pa_q  <= pa_q + STEP64;
      ia_q  <= ia_q + STEP;
      cnt_q <= cnt_q - STEP;
    end else if (!active_q) begin
      if (wr_pa_lo_i) pa_q[31:0]  <= wdata_i;
      if (wr_pa_hi_i) pa_q[63:32] <= wdata_i;
      if (wr_ia_i)    ia_q        <= wdata_i;
      if (wr_cnt_i)   cnt_q       <= wdata_i;
    end
  end

  assign active_o = active_q;
  assign pa_o     = pa_q;
  assign ia_o     = ia_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/xfer_status.sv
module xfer_status
  import xfer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [NFLAG-1:0] wr_flags_i,
  input  logic [NFLAG-1:0] wr_ens_i,
  input  logic [NFLAG-1:0] ev_i,
  output logic [NFLAG-1:0] flags_o,
  output logic [NFLAG-1:0] ens_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] flag_q, en_q;

  generate
    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          flag_q[k] <= 1'b0;
          en_q[k]   <= 1'b0;
        end else begin
          // a new event beats a same-cycle clear
          if (ev_i[k])                       flag_q[k] <= 1'b1;
          else if (we_i && wr_flags_i[k])    flag_q[k] <= 1'b0;
          if (we_i)                          en_q[k]   <= wr_ens_i[k];
        end
      end
    end
  endgenerate

  assign flags_o = flag_q;
  assign ens_o   = en_q;
  assign irq_o   = |(flag_q & en_q);
endmodule

// File: rtl/xfer_chan_ctl.sv
module xfer_chan_ctl
  import xfer_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned CH_BASE    = 'h100,
  parameter int unsigned BEAT_BYTES = 8,
  parameter logic [31:0] MAX_CNT    = 32'h07FF_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic              beat_dir_o,
  output logic [63:0]       beat_pcie_addr_o,
  output logic [31:0]       beat_int_addr_o,
  input  logic              pcie_err_i,
  input  logic              int_err_i,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_GLB   = '0;
  localparam logic [ADDR_W-1:0] A_PA_LO = ADDR_W'(CH_BASE + OFF_PA_LO);
  localparam logic [ADDR_W-1:0] A_PA_HI = ADDR_W'(CH_BASE + OFF_PA_HI);
  localparam logic [ADDR_W-1:0] A_IA    = ADDR_W'(CH_BASE + OFF_IA);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(CH_BASE + OFF_CNT);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CH_BASE + OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(CH_BASE + OFF_STAT);

  logic             en_q, go_q, dir_q;
  logic             active, stop, size_ok;
  logic [63:0]      pa;
  logic [31:0]      ia, cnt;
  logic [NFLAG-1:0] ev, flags, ens, wr_flags, wr_ens;
  logic [31:0]      stat_word;
  logic             we_glb, we_ctrl, we_stat;

  assign we_glb  = reg_we_i && (reg_addr_i == A_GLB);
  assign we_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  assign we_stat = reg_we_i && (reg_addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      go_q  <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      if (we_glb) en_q <= reg_wdata_i[GLB_EN_B];
      if (we_ctrl) begin
        go_q  <= reg_wdata_i[CTL_GO_B];
        dir_q <= reg_wdata_i[CTL_DIR_B];
      end else if (stop) begin
        go_q  <= 1'b0;
      end
    end
  end

  xfer_size_chk #(.BEAT_BYTES(BEAT_BYTES), .MAX_CNT(MAX_CNT)) i_size_chk (
    .cnt_i (cnt),
    .ok_o  (size_ok)
  );

  xfer_engine #(.BEAT_BYTES(BEAT_BYTES)) i_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_q),
    .go_i       (go_q),
    .size_ok_i  (size_ok),
    .wr_pa_lo_i (reg_we_i && (reg_addr_i == A_PA_LO)),
    .wr_pa_hi_i (reg_we_i && (reg_addr_i == A_PA_HI)),
    .wr_ia_i    (reg_we_i && (reg_addr_i == A_IA)),
    .wr_cnt_i   (reg_we_i && (reg_addr_i == A_CNT)),
    .wdata_i    (reg_wdata_i),
    .ready_i    (beat_ready_i),
    .pcie_err_i (pcie_err_i),
    .int_err_i  (int_err_i),
    .active_o   (active),
    .pa_o       (pa),
    .ia_o       (ia),
    .cnt_o      (cnt),
    .ev_o       (ev),
    .stop_o     (stop)
  );

  always_comb begin
    stat_word = '0;
    wr_flags  = '0;
    wr_ens    = '0;
    for (int unsigned k = 0; k < NFLAG; k++) begin
      stat_word[flag_pos(k)] = flags[k];
      stat_word[en_pos(k)]   = ens[k];
      wr_flags[k]            = reg_wdata_i[flag_pos(k)];
      wr_ens[k]              = reg_wdata_i[en_pos(k)];
    end
  end

  xfer_status i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_stat),
    .wr_flags_i (wr_flags),
    .wr_ens_i   (wr_ens),
    .ev_i       (ev),
    .flags_o    (flags),
    .ens_o      (ens),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_GLB: begin
        reg_rdata_o[GLB_EN_B]  = en_q;
        reg_rdata_o[GLB_ACT_B] = active;
      end
      A_PA_LO: reg_rdata_o = pa[31:0];
      A_PA_HI: reg_rdata_o = pa[63:32];
      A_IA:    reg_rdata_o = ia;
      A_CNT:   reg_rdata_o = cnt;
      A_CTRL: begin
        reg_rdata_o[CTL_GO_B]  = go_q;
        reg_rdata_o[CTL_DIR_B] = dir_q;
      end
      A_STAT:  reg_rdata_o = stat_word;
      default: reg_rdata_o = '0;
    endcase
  end

  assign beat_valid_o     = active;
  assign beat_dir_o       = dir_q;
  assign beat_pcie_addr_o = pa;
  assign beat_int_addr_o  = ia;
endmodule

// File: rtl/xfer_chan_chk.sv
module xfer_chan_chk #(
  parameter int unsigned BEAT_BYTES = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        beat_valid_i,
  input logic        beat_ready_i,
  input logic        pcie_err_i,
  input logic        int_err_i,
  input logic [63:0] pa_i,
  input logic [31:0] ia_i,
  input logic [31:0] cnt_i,
  input logic [3:0]  flags_i,
  input logic        irq_i
);
  localparam logic [31:0] STEP   = 32'(BEAT_BYTES);
  localparam logic [63:0] STEP64 = 64'(BEAT_BYTES);

  // R5
  beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && beat_ready_i && !pcie_err_i && !int_err_i) |=>
      (pa_i == $past(pa_i) + STEP64) && (ia_i == $past(ia_i) + STEP) &&
      (cnt_i == $past(cnt_i) - STEP));

  // R6
  last_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && beat_ready_i && !pcie_err_i && !int_err_i && cnt_i == STEP) |=>
      (!beat_valid_i && flags_i[0] && cnt_i == '0));

  // R7
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && (pcie_err_i || int_err_i)) |=>
      (!beat_valid_i && (cnt_i == $past(cnt_i)) && (flags_i[1] || flags_i[2])));

  // R3
  nonzero_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_i |-> (cnt_i != '0));

  // R10
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (flags_i != '0));
endmodule

bind xfer_chan_ctl xfer_chan_chk #(.BEAT_BYTES(BEAT_BYTES)) i_xfer_chan_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .beat_valid_i (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .pcie_err_i   (pcie_err_i),
  .int_err_i    (int_err_i),
  .pa_i         (pa),
  .ia_i         (ia),
  .cnt_i        (cnt),
  .flags_i      (flags),
  .irq_i        (irq_o)
);

// File: tb/test_xfer_chan_ctl.sv
`timescale 1ns/1ps
module test_xfer_chan_ctl;
  localparam logic [31:0] MAXC = 32'h40;
  localparam logic [15:0] CH   = 16'h0100;
  localparam logic [15:0] A_GLB = 16'h0000, A_PL = CH + 16'h00, A_PH = CH + 16'h04,
                          A_IA = CH + 16'h08, A_CNT = CH + 16'h10,
                          A_CTL = CH + 16'h28, A_ST = CH + 16'h2C;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [15:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        beat_valid_o, beat_ready_i = 1'b0, beat_dir_o, irq_o;
  logic [63:0] beat_pcie_addr_o;
  logic [31:0] beat_int_addr_o;
  logic        pcie_err_i = 1'b0, int_err_i = 1'b0;

  int          total = 0, bad = 0, beats = 0, mode = 0, cyc = 0;
  bit          finished = 0;
  logic [63:0] exp_pa;
  logic [31:0] exp_ia;
  logic        exp_dir;

  always #2.5 clk_i = ~clk_i;

  xfer_chan_ctl #(.MAX_CNT(MAXC)) i_xfer_chan_ctl (.*);

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < 400 && beat_valid_o; i++) @(negedge clk_i);
  endtask

  task automatic clear_stat();
    logic [31:0] v;
    rd(A_ST, v);
    wr(A_ST, v);
    wr(A_ST, 32'h0);
  endtask

  task automatic load(input logic [63:0] pa, input logic [31:0] ia, input logic [31:0] n);
    wr(A_PL, pa[31:0]); wr(A_PH, pa[63:32]); wr(A_IA, ia); wr(A_CNT, n);
    exp_pa = pa; exp_ia = ia; beats = 0;
  endtask

  // ready patterns
  always @(negedge clk_i) begin
    cyc++;
    case (mode)
      0:       beat_ready_i = 1'b0;
      1:       beat_ready_i = 1'b1;
      default: beat_ready_i = (cyc % 3 != 1);
    endcase
  end

  // beat monitor
  always @(posedge clk_i) begin
    if (rst_ni && beat_valid_o && beat_ready_i && !pcie_err_i && !int_err_i) begin
      chk("R5 beat pcie addr", beat_pcie_addr_o, exp_pa);
      chk("R5 beat int addr", {32'h0, beat_int_addr_o}, {32'h0, exp_ia});
      chk("R12 dir", {63'h0, beat_dir_o}, {63'h0, exp_dir});
      exp_pa = exp_pa + 64'd8;
      exp_ia = exp_ia + 32'd8;
      beats++;
    end
  end

  task automatic run_one(input int n, input logic dir, input int md);
    logic [31:0] v;
    logic [63:0] base;
    bit ok;
    base = {32'h0000_0005, 32'hFFFF_FFC0};
    mode = md;
    load(base, 32'h2000_0100, n);
    exp_dir = dir;
    wr(A_CTL, {1'b1, dir, 30'h0});
    wait_idle();
    mode = 0;
    ok = (n <= MAXC) && (n % 8 == 0);
    if (ok) begin
      chk("R5 beat count", beats, n / 8);
      rd(A_CNT, v); chk("R6 count zero", v, 0);
      rd(A_ST, v);  chk("R6 end flag only", {v[12], v[11], v[9], v[0]}, 4'b0001);
      rd(A_PL, v);  chk("R5 pcie lo final", v, 32'(base + 64'(n)));
      rd(A_PH, v);  chk("R5 pcie hi final", v, 32'((base + 64'(n)) >> 32));
      rd(A_IA, v);  chk("R5 int final", v, 32'h2000_0100 + n);
      rd(A_CTL, v); chk("R6 start clears", v[31], 0);
    end else begin
      chk("R4 no beats", beats, 0);
      rd(A_CNT, v); chk("R4 count kept", v, n);
      rd(A_ST, v);  chk("R4 abort flag only", {v[12], v[11], v[9], v[0]}, 4'b1000);
      rd(A_CTL, v); chk("R4 start clears", v[31], 0);
    end
    rd(A_GLB, v); chk("R3 active low when idle", v[16], 0);
    clear_stat();
    rd(A_ST, v); chk("R9 flags cleared", v, 0);
  endtask

  task automatic err_case(input bit pcie_side);
    logic [31:0] v;
    int n;
    wr(A_ST, pcie_side ? (32'h1 << 27) : (32'h1 << 25));
    mode = 1;
    load(64'h0000_0001_0000_0000, 32'h3000_0000, 32'd64);
    exp_dir = 1'b0;
    wr(A_CTL, 32'h8000_0000);
    for (int i = 0; i < 50 && beats < 3; i++) @(negedge clk_i);
    if (pcie_side) pcie_err_i = 1'b1; else int_err_i = 1'b1;
    @(negedge clk_i);
    pcie_err_i = 1'b0; int_err_i = 1'b0; mode = 0;
    repeat (2) @(negedge clk_i);
    n = beats;
    chk("R7 stopped", beat_valid_o, 0);
    rd(A_CNT, v); chk("R7 remaining count", v, 64 - 8 * n);
    rd(A_ST, v);
    chk("R7 flag set", {v[12], v[11], v[9], v[0]}, pcie_side ? 4'b0100 : 4'b0010);
    rd(A_CTL, v); chk("R7 start clears", v[31], 0);
    chk("R10 irq on enabled error", irq_o, 1);
    wr(A_ST, pcie_side ? (32'h1 << 27) : (32'h1 << 25));
    rd(A_ST, v); chk("R9 zero write keeps flag", pcie_side ? v[11] : v[9], 1);
    clear_stat();
    @(negedge clk_i);
    chk("R10 irq off after clear", irq_o, 0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1 valid", beat_valid_o, 0);
    chk("R1 irq", irq_o, 0);
    rd(A_GLB, v); chk("R1 glb", v, 0);
    rd(A_PL, v);  chk("R1 pa lo", v, 0);
    rd(A_PH, v);  chk("R1 pa hi", v, 0);
    rd(A_IA, v);  chk("R1 ia", v, 0);
    rd(A_CNT, v); chk("R1 cnt", v, 0);
    rd(A_CTL, v); chk("R1 ctrl", v, 0);
    rd(A_ST, v);  chk("R1 stat", v, 0);
    // R2 map and R9 enables
    wr(A_PL, 32'h1234_5678); wr(A_PH, 32'h9ABC_DEF0); wr(A_IA, 32'h0F0F_0F08);
    wr(A_CNT, 32'hFFFF_FFF8); wr(A_CTL, 32'h4000_0000); wr(A_ST, 32'h1A00_0008);
    rd(A_PL, v);  chk("R2 pa lo", v, 32'h1234_5678);
    rd(A_PH, v);  chk("R2 pa hi", v, 32'h9ABC_DEF0);
    rd(A_IA, v);  chk("R2 ia", v, 32'h0F0F_0F08);
    rd(A_CNT, v); chk("R2 cnt", v, 32'hFFFF_FFF8);
    rd(A_CTL, v); chk("R2 R12 dir bit", v, 32'h4000_0000);
    chk("R12 dir out", beat_dir_o, 1);
    rd(A_ST, v);  chk("R9 enables rw", v, 32'h1A00_0008);
    chk("R10 no flag no irq", irq_o, 0);
    wr(A_ST, 0); wr(A_CTL, 0);
    // R3 zero count pending
    wr(A_GLB, 32'h8000_0000);
    wr(A_CNT, 0); beats = 0; mode = 1;
    wr(A_CTL, 32'h8000_0000);
    repeat (4) @(negedge clk_i);
    chk("R3 zero count no beat", beats, 0);
    chk("R3 zero count idle", beat_valid_o, 0);
    rd(A_CTL, v); chk("R3 start held", v[31], 1);
    wr(A_CTL, 0);
    // R3 global enable gating, R10 end irq
    wr(A_GLB, 0); wr(A_ST, 32'h8);
    load(64'h40, 32'h80, 32'd16); exp_dir = 1'b0;
    wr(A_CTL, 32'h8000_0000);
    repeat (4) @(negedge clk_i);
    chk("R3 disabled no beat", beats, 0);
    wr(A_GLB, 32'h8000_0000);
    wait_idle();
    chk("R3 runs once enabled", beats, 2);
    chk("R10 end irq", irq_o, 1);
    wr(A_ST, 32'h8);
    rd(A_ST, v); chk("R9 zero write keeps end", v[0], 1);
    wr(A_ST, 0);
    @(negedge clk_i);
    chk("R10 disabled no irq", irq_o, 0);
    wr(A_ST, 32'h1);
    rd(A_ST, v); chk("R9 w1c end", v, 0);
    // sweep
    for (int n = 1; n <= 80; n++) run_one(n, n[0], (n % 3 == 0) ? 2 : 1);
    // R7 errors
    err_case(1'b1);
    err_case(1'b0);
    // R11 and R8 via start bit
    mode = 0;
    load(64'h1000, 32'h2000, 32'd64); exp_dir = 1'b1;
    wr(A_CTL, 32'hC000_0000);
    repeat (2) @(negedge clk_i);
    chk("R3 valid while running", beat_valid_o, 1);
    rd(A_GLB, v); chk("R3 active flag", v[16], 1);
    wr(A_CNT, 32'd16); wr(A_PL, 32'h0);
    rd(A_CNT, v); chk("R11 count write ignored", v, 64);
    rd(A_PL, v);  chk("R11 addr write ignored", v, 32'h1000);
    wr(A_ST, 32'h1 << 28);
    wr(A_CTL, 32'h4000_0000);
    repeat (2) @(negedge clk_i);
    chk("R8 stopped", beat_valid_o, 0);
    rd(A_ST, v);  chk("R8 abort flag", v[12], 1);
    rd(A_CNT, v); chk("R8 count kept", v, 64);
    chk("R10 abort irq", irq_o, 1);
    clear_stat();
    // R8 via global enable
    wr(A_CTL, 32'h8000_0000);
    repeat (2) @(negedge clk_i);
    wr(A_GLB, 0);
    repeat (2) @(negedge clk_i);
    chk("R8 global stop", beat_valid_o, 0);
    rd(A_ST, v); chk("R8 abort on disable", v[12], 1);
    rd(A_CTL, v); chk("R8 start clears", v[31], 0);
    clear_stat();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule